// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing half of a byte-addressed serial memory with 8K locations. It watches oversampled SCL and SDA lines and recognises START and STOP conditions. It accepts a control byte that carries a fixed device-type code and three chip-select bits, which must match strap inputs. After that it takes a two-byte word address and serves byte writes, current-address reads, random reads and sequential reads. SDA is driven through an open-drain enable, so `sda_oe` high pulls the line low.

Reads go to a synchronous memory port. The port is addressed by the internal pointer and returns data one clock later. Writes are handed to a separate commit block at STOP, using a start pulse. While that block reports busy, the engine holds back every acknowledge, so a master can poll for completion with a bare control byte.

Both bus lines pass through a two-flop synchroniser on a system clock that runs at least eight times the bus rate. The engine moves its own SDA only a fixed number of system clocks after it sees SCL fall. This keeps it from creating a false START or STOP.

Top module: `i2c_mem_slave`

## Requirements
- R1: A START (SDA falling while SCL high) in any state discards any pending write and restarts control-byte reception. A STOP (SDA rising while SCL high) returns the engine to idle.
- R2: In the control byte, bits 7:4 must equal 4'b1010 and bits 3:1 must equal `cs_strap`. Bit 0 selects read (1) or write (0). Only a matching byte is acknowledged. On a mismatch SDA stays released and all later bytes are ignored until the next START.
- R3: A write header carries the address high byte first, then the low byte. The pointer becomes {high[4:0], low}, and high[7:5] have no effect.
- R4: The engine acknowledges a byte by pulling SDA low after the eighth SCL fall. It keeps SDA low through the whole high phase of the ninth clock and releases it after the ninth fall.
- R5: Each acknowledged data byte of a write becomes the pending write at the current pointer, and the pointer advances by one. At STOP the most recent pending byte is committed by a one-cycle `commit_start` pulse carrying `commit_addr` and `commit_data`.
- R6: A repeated START after a write header or a data byte commits nothing, and the pointer keeps its value.
- R7: After a read control byte, the engine sends the memory byte at the pointer, MSB first. The pointer advances by one for each byte sent, so a read without a header returns the location after the last one accessed.
- R8: During a read, SDA low from the master on the ninth clock requests the next byte. SDA high on the ninth clock makes the engine release SDA and send nothing more until a START.
- R9: The 13-bit pointer advances from 1FFF to 0000.
- R10: While `commit_busy` is high, no byte is acknowledged, including a matching control byte.
- R11: The engine's SDA enable changes only while SCL is low, a delay of HOLD_CYC system clocks after the synchronised SCL fall.

Port widths: `cs_strap` is 3 bits, the memory and commit address ports are 13 bits, and the data ports are 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| cs_strap | input | 3 | Chip-select value this slave answers to |
| mem_addr | output | 13 | Read address to the memory (the pointer) |
| mem_rdata | input | 8 | Memory read data, valid one clock after `mem_addr` |
| commit_start | output | 1 | One-cycle pulse that launches a write commit |
| commit_addr | output | 13 | Address of the byte to commit |
| commit_data | output | 8 | Byte to commit |
| commit_busy | input | 1 | High while the commit block is writing |

## Verification
The bench uses the default parameters: device code 1010 and HOLD_CYC = 3. It runs a 32-clock bus bit period, which leaves the output delay well inside the SCL low phase. The strap is fixed at 3'b101. With this setup the bench sweeps all eight chip-select values and all sixteen device codes. It can also reach the 1FFF-to-0000 pointer wrap with a short sequential read.

The memory model returns a computed pattern for every unwritten address. The commit model stays busy for 1000 clocks, which is long enough for two polls to fall inside one commit window.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  localparam int PTR_W = 13;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADRH,
    ST_ADRL,
    ST_WDATA,
    ST_RDATA
  } st_t;

  // control byte matches device code and strap bits
  function automatic logic ctrl_hit(input logic [7:0] b, input logic [3:0] code,
                                    input logic [2:0] cs);
    return (b[7:4] == code) && (b[3:1] == cs);
  endfunction

  // word address from the two header bytes; spare high bits dropped
  function automatic logic [PTR_W-1:0] join_addr(input logic [7:0] hi, input logic [7:0] lo);
    return {hi[PTR_W-9:0], lo};
  endfunction

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction
endpackage

// File: rtl/i2cm_line_sync.sv
`timescale 1ns/1ps
module i2cm_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_sh, sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  assign scl_s     = scl_sh[1];
  assign sda_s     = sda_sh[1];
  assign scl_rise  = scl_sh[1] & ~scl_sh[2];
  assign scl_fall  = ~scl_sh[1] & scl_sh[2];
  assign start_det = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
  assign stop_det  = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];
endmodule

// File: rtl/i2cm_ptr.sv
`timescale 1ns/1ps
module i2cm_ptr import i2cm_pkg::*; #(
  parameter int W = PTR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr_step(ptr);
  end

  assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && (ptr == {W{1'b1}})) |=> (ptr == '0))
    else $error("pointer did not wrap to zero");
endmodule

// File: rtl/i2cm_sda_hold.sv
`timescale 1ns/1ps
module i2cm_sda_hold #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic req,
  input  logic req_low,
  output logic sda_oe
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  logic [CW-1:0] cnt;
  logic          pend, tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_oe <= 1'b0; pend <= 1'b0; tgt <= 1'b0; cnt <= '0;
    end else if (kill) begin
      sda_oe <= 1'b0; pend <= 1'b0;
    end else if (req) begin
      tgt <= req_low; pend <= 1'b1; cnt <= CW'(HOLD_CYC);
    end else if (pend) begin
      if (cnt <= CW'(1)) begin
        sda_oe <= tgt; pend <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave.sv
`timescale 1ns/1ps
module i2c_mem_slave import i2cm_pkg::*; #(
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int         HOLD_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [2:0]       cs_strap,
  output logic [PTR_W-1:0] mem_addr,
  input  logic [7:0]       mem_rdata,
  output logic             commit_start,
  output logic [PTR_W-1:0] commit_addr,
  output logic [7:0]       commit_data,
  input  logic             commit_busy
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, kill;
  st_t st;
  logic [3:0] bitcnt;
  logic ack_ph, rw, mack, pend_v;
  logic [7:0] shreg, hi_q, pend_d;
  logic [PTR_W-1:0] pend_a, ptr;
  logic drv_req, drv_low, ptr_ld, ptr_inc, commit_q;
  // named events for assertions
  logic byte_done, ack_end, ack_go;

  i2cm_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cm_ptr #(.W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_ld), .load_val(join_addr(hi_q, shreg)),
    .inc(ptr_inc), .ptr(ptr)
  );

  i2cm_sda_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .kill(kill), .req(drv_req), .req_low(drv_low),
    .sda_oe(sda_oe)
  );

  assign kill      = start_det | stop_det;
  assign byte_done = scl_fall && (bitcnt == ACK_SLOT) && !ack_ph;
  assign ack_end   = scl_fall && (bitcnt == ACK_SLOT) && ack_ph;
  assign ack_go    = !commit_busy && ((st != ST_CTRL) || ctrl_hit(shreg, DEV_CODE, cs_strap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; ack_ph <= 1'b0; rw <= 1'b0; mack <= 1'b0;
      shreg <= '0; hi_q <= '0; pend_v <= 1'b0; pend_a <= '0; pend_d <= '0;
      drv_req <= 1'b0; drv_low <= 1'b0; ptr_ld <= 1'b0; ptr_inc <= 1'b0; commit_q <= 1'b0;
    end else begin
      drv_req <= 1'b0; ptr_ld <= 1'b0; ptr_inc <= 1'b0; commit_q <= 1'b0;
      if (start_det) begin
        st <= ST_CTRL; bitcnt <= '0; ack_ph <= 1'b0; pend_v <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; bitcnt <= '0; ack_ph <= 1'b0;
        commit_q <= pend_v; pend_v <= 1'b0;
      end else if (st == ST_RDATA) begin
        if (scl_rise) begin
          if (bitcnt != ACK_SLOT) bitcnt <= bitcnt + 1'b1;
          else                    mack   <= !sda_s;
        end else if (scl_fall) begin
          if (bitcnt != ACK_SLOT) begin
            drv_req <= 1'b1; drv_low <= !shreg[6]; shreg <= {shreg[6:0], 1'b0};
          end else if (!ack_ph) begin
            drv_req <= 1'b1; drv_low <= 1'b0; ack_ph <= 1'b1;
          end else begin
            ack_ph <= 1'b0; bitcnt <= '0; drv_req <= 1'b1;
            if (mack) begin
              shreg <= mem_rdata; drv_low <= !mem_rdata[7]; ptr_inc <= 1'b1;
            end else begin
              drv_low <= 1'b0; st <= ST_IDLE;
            end
          end
        end
      end else if (st != ST_IDLE) begin
        if (scl_rise && (bitcnt != ACK_SLOT)) begin
          shreg <= {shreg[6:0], sda_s}; bitcnt <= bitcnt + 1'b1;
        end else if (byte_done) begin
          if (ack_go) begin
            drv_req <= 1'b1; drv_low <= 1'b1; ack_ph <= 1'b1;
            case (st)
              ST_CTRL:  rw <= shreg[0];
              ST_ADRH:  hi_q <= shreg;
              ST_ADRL:  ptr_ld <= 1'b1;
              ST_WDATA: begin
                pend_v <= 1'b1; pend_a <= ptr; pend_d <= shreg; ptr_inc <= 1'b1;
              end
              default: ;
            endcase
          end else begin
            st <= ST_IDLE;
          end
        end else if (ack_end) begin
          ack_ph <= 1'b0; bitcnt <= '0; drv_req <= 1'b1; drv_low <= 1'b0;
          case (st)
            ST_CTRL: if (rw) begin
                       st <= ST_RDATA; shreg <= mem_rdata;
                       drv_low <= !mem_rdata[7]; ptr_inc <= 1'b1;
                     end else begin
                       st <= ST_ADRH;
                     end
            ST_ADRH: st <= ST_ADRL;
            ST_ADRL: st <= ST_WDATA;
            default: ;
          endcase
        end
      end
    end
  end

  assign mem_addr     = ptr;
  assign commit_start = commit_q;
  assign commit_addr  = pend_a;
  assign commit_data  = pend_d;

  assert_oe_still_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(kill)) |-> $stable(sda_oe))
    else $error("SDA enable moved while SCL high");

  assert_busy_mute_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_busy |-> !sda_oe)
    else $error("SDA driven while commit busy");

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe)
    else $error("SDA driven while idle");

  assert_commit_at_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |-> (st == ST_IDLE))
    else $error("commit launched outside a STOP");
endmodule

// File: tb/i2c_mem_slave_bench.sv
`timescale 1ns/1ps
module i2c_mem_slave_bench;
  localparam int BUSY_CYC = 1000;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW_WR = {4'hA, STRAP, 1'b0};
  localparam logic [7:0] CW_RD = {4'hA, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, sda_bus, commit_start, commit_busy;
  logic [12:0] mem_addr, commit_addr;
  logic [7:0] mem_rdata, commit_data;
  int busy_cnt;
  int n_chk = 0, n_fail = 0, n_commit = 0, oe_viol = 0;
  logic [12:0] last_ca;
  logic [7:0]  last_cd;
  logic done = 1'b0;
  logic scl_d = 1'b1, oe_d = 1'b0;
  logic [7:0] ram [int];

  always #4 clk = ~clk;

  assign sda_bus = !(m_low || sda_oe);
  assign commit_busy = (busy_cnt != 0);

  i2c_mem_slave u_i2c_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .cs_strap(STRAP), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .commit_start(commit_start), .commit_addr(commit_addr), .commit_data(commit_data),
    .commit_busy(commit_busy)
  );

  function automatic logic [7:0] pat(input logic [12:0] a);
    return 8'((a * 13) ^ (a >> 8) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [12:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : pat(a);
  endfunction

  always @(posedge clk) mem_rdata <= exp_rd(mem_addr);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else if (commit_start) begin
      ram[int'(commit_addr)] = commit_data;
      n_commit = n_commit + 1;
      last_ca = commit_addr;
      last_cd = commit_data;
      busy_cnt <= BUSY_CYC;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end

  // R11 monitor: enable must not move during a held SCL high
  always @(negedge clk) begin
    if (rst_n && scl && scl_d && (sda_oe != oe_d)) oe_viol = oe_viol + 1;
    scl_d = scl;
    oe_d  = sda_oe;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    m_low = 1'b0; tick(8); scl = 1'b1; tick(8); m_low = 1'b1; tick(8); scl = 1'b0;
  endtask

  task automatic m_stop;
    tick(8); m_low = 1'b1; tick(8); scl = 1'b1; tick(8); m_low = 1'b0; tick(8);
  endtask

  task automatic m_bit(input logic b);
    tick(8); m_low = !b; tick(8); scl = 1'b1; tick(16); scl = 1'b0;
  endtask

  // samples early and late in the high phase; reports high if either sample is high
  task automatic m_rbit(output logic b);
    logic s1, s2;
    tick(8); m_low = 1'b0; tick(8); scl = 1'b1;
    tick(3); s1 = sda_bus; tick(10); s2 = sda_bus; tick(3); scl = 1'b0;
    b = s1 | s2;
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit(d[i]);
    m_rbit(b);
    ack = !b;
  endtask

  task automatic m_rbyte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_rbit(b);
      d[i] = b;
    end
    m_bit(!mack);
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    m_start;
    m_wbyte(CW_WR, a); check(a, "R2 header ctrl ack", a, 1);
    m_wbyte(hi, a);    check(a, "R3 high addr ack", a, 1);
    m_wbyte(lo, a);    check(a, "R3 low addr ack", a, 1);
  endtask

  task automatic wait_idle;
    while (commit_busy) tick(1);
    tick(4);
  endtask

  initial begin
    logic a1, a2;
    logic [7:0] d;
    int c0;
    tick(5);
    check(sda_oe == 1'b0, "R2 reset releases SDA", sda_oe, 0);
    check(commit_start == 1'b0, "R5 no commit in reset", commit_start, 0);
    rst_n = 1'b1;
    tick(5);
    check(mem_addr == 13'h0, "R7 pointer after reset", mem_addr, 0);

    // R2: chip-select sweep, then device-code sweep
    for (int cs = 0; cs < 8; cs++) begin
      m_start;
      m_wbyte({4'hA, 3'(cs), 1'b0}, a1);
      m_wbyte(8'h00, a2);
      m_stop;
      check(a1 == (cs == int'(STRAP)), "R2 chip-select match", a1, cs == int'(STRAP));
      check(a2 == (cs == int'(STRAP)), "R2 ignored after mismatch", a2, cs == int'(STRAP));
    end
    for (int code = 0; code < 16; code++) begin
      m_start;
      m_wbyte({4'(code), STRAP, 1'b0}, a1);
      m_wbyte(8'h00, a2);
      m_stop;
      check(a1 == (code == 10), "R2 device code match", a1, code == 10);
      check(a2 == (code == 10), "R2 ignored after bad code", a2, code == 10);
    end

    // R3/R4/R5: byte write, spare high bits set
    c0 = n_commit;
    set_addr(8'hE1, 8'h23);
    m_wbyte(8'h5C, a1);
    check(a1, "R4 data byte ack held through high phase", a1, 1);
    m_stop;
    tick(2);
    check(n_commit == c0 + 1, "R5 one commit", n_commit, c0 + 1);
    check(last_ca == 13'h0123, "R3 spare high bits ignored", last_ca, 13'h0123);
    check(last_cd == 8'h5C, "R5 commit data", last_cd, 8'h5C);
    check(mem_addr == 13'h0124, "R5 pointer after write", mem_addr, 13'h0124);

    // R10: polls while busy get no ack
    m_start; m_wbyte(CW_WR, a1); m_stop;
    check(!a1, "R10 write poll while busy", a1, 0);
    m_start; m_wbyte(CW_RD, a1); m_stop;
    check(!a1, "R10 read poll while busy", a1, 0);
    check(commit_busy == 1'b1, "R10 still inside busy window", commit_busy, 1);
    wait_idle;
    m_start; m_wbyte(CW_WR, a1); m_stop;
    check(a1, "R10 poll after busy", a1, 1);

    // R7/R8: current-address read
    m_start; m_wbyte(CW_RD, a1);
    check(a1, "R7 read ctrl ack", a1, 1);
    m_rbyte(d, 1'b0);
    check(d == exp_rd(13'h0124), "R7 current address read", d, exp_rd(13'h0124));
    check(sda_bus == 1'b1, "R8 SDA released after NACK", sda_bus, 1);
    m_stop;
    check(mem_addr == 13'h0125, "R7 pointer after read", mem_addr, 13'h0125);

    // random read of the written byte
    set_addr(8'h01, 8'h23);
    m_start; m_wbyte(CW_RD, a1);
    m_rbyte(d, 1'b0); m_stop;
    check(d == 8'h5C, "R7 random read of committed byte", d, 8'h5C);

    // R6: repeated START discards the pending byte
    c0 = n_commit;
    set_addr(8'h00, 8'h40);
    m_wbyte(8'h77, a1);
    m_start; m_wbyte(CW_RD, a1);
    m_rbyte(d, 1'b0); m_stop;
    check(d == exp_rd(13'h0041), "R6 pointer kept across repeated START", d, exp_rd(13'h0041));
    check(n_commit == c0, "R6 no commit on repeated START", n_commit, c0);
    set_addr(8'h00, 8'h40);
    m_start; m_wbyte(CW_RD, a1);
    m_rbyte(d, 1'b0); m_stop;
    check(d == pat(13'h0040), "R6 location untouched", d, pat(13'h0040));

    // R8/R9: sequential read across the top of the space
    set_addr(8'hFF, 8'hFD);
    m_start; m_wbyte(CW_RD, a1);
    for (int i = 0; i < 5; i++) begin
      logic [12:0] ea;
      ea = 13'(13'h1FFD + i);
      m_rbyte(d, i != 4);
      check(d == exp_rd(ea), "R9 sequential read with wrap", d, exp_rd(ea));
    end
    m_stop;
    check(mem_addr == 13'h0002, "R9 pointer after wrap", mem_addr, 13'h0002);

    // R1: START in the middle of a header restarts control reception
    m_start; m_wbyte(CW_WR, a1); m_wbyte(8'h0A, a1);
    m_start; m_wbyte(CW_RD, a1);
    check(a1, "R1 control ack after abort", a1, 1);
    m_rbyte(d, 1'b0); m_stop;
    check(d == exp_rd(13'h0002), "R1 aborted header leaves pointer", d, exp_rd(13'h0002));

    // R5: two data bytes, only the last one is committed
    c0 = n_commit;
    set_addr(8'h02, 8'h00);
    m_wbyte(8'h11, a1); m_wbyte(8'h22, a2); m_stop;
    tick(2);
    check(n_commit == c0 + 1, "R5 single commit for two bytes", n_commit, c0 + 1);
    check(last_ca == 13'h0201 && last_cd == 8'h22, "R5 last byte committed",
          {last_ca, last_cd}, {13'h0201, 8'h22});
    wait_idle;
    set_addr(8'h02, 8'h00);
    m_start; m_wbyte(CW_RD, a1);
    m_rbyte(d, 1'b1);
    check(d == pat(13'h0200), "R5 earlier byte not committed", d, pat(13'h0200));
    m_rbyte(d, 1'b0); m_stop;
    check(d == 8'h22, "R8 ack fetched next byte", d, 8'h22);

    check(oe_viol == 0, "R11 SDA enable stable while SCL high", oe_viol, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule